// File: doc/BRIEF.md
# Selectable-Depth Page Table Walker

This block turns a 64-bit virtual address into a physical address. It walks a tree of page tables kept in memory and reads one 8-byte entry per level. A single control bit, the depth mode, chooses between a four-level walk and a five-level walk. The five-level walk adds a top table indexed by a further 9-bit slice of the address. Before any memory traffic, every request goes through a canonical-address check, and that check follows the depth mode in force.

A client offers a request carrying the virtual address and the frame number of the root table. The request is taken only while the walker is idle. The walker then issues entry reads, one at a time, over a valid/ready request port and collects each entry from a valid response. The walk ends with a one-cycle result that holds one of two things:
- the physical address, which is the final frame joined with the 12-bit page offset, or
- a fault with a cause code and the level at which the walk stopped.

The depth mode lives in bit 12 of a control word. A write may change it only while the processor is outside 64-bit mode. A write that tries to change it inside that mode is dropped, and an error flag pulses for one cycle. The depth mode is captured when a walk starts and stays fixed for that walk.

The control FSM has four states:
- `ST_IDLE`: ready for a request.
- `ST_ISSUE`: the entry read is presented on the memory port.
- `ST_WAIT`: waiting for the entry.
- `ST_DONE`: the result is shown for one cycle.

It has these transitions:
- IDLE→ISSUE: a request is taken and the address is canonical.
- IDLE→DONE: a request is taken and the address is non-canonical.
- ISSUE→WAIT: the memory port accepts the read.
- WAIT→ISSUE: the entry is present and levels remain.
- WAIT→DONE: the entry is not present, or this was the last level.
- DONE→IDLE: always.

Top module: `ptw_top`

## Requirements
- R1: `deep_mode_o` mirrors bit 12 of the control word. A control write (`cfg_wr_en`=1) with `long_mode_i`=0 loads `cfg_wr_data[12]` into it, visible one cycle later.
- R2: With `long_mode_i`=1, a control write whose bit 12 differs from `deep_mode_o` leaves the mode unchanged and raises `cfg_err_o` for exactly one cycle. A write of the same value raises no error.
- R3: With mode 0 the walk makes exactly 4 entry reads. Level L (L=4..1) is indexed by address bits [12+9(L-1)+8 : 12+9(L-1)], so the order is 47:39, 38:30, 29:21, 20:12. Each read address is {table frame, index, 3'b000}.
- R4: With mode 1 the walk makes exactly 5 entry reads. The first uses the index in address bits 56:48 against the root table, and the rest follow R3's order.
- R5: Canonical rule: with mode 1, bits 63:57 must equal bit 56; with mode 0, bits 63:48 must equal bit 47. A violating request completes one cycle after acceptance with `done_fault`=1, `done_cause`=1, `done_level`=0, and makes no memory read.
- R6: Entry bit 0 is the present bit. A clear present bit ends the walk with `done_fault`=1, `done_cause`=2, and `done_level` set to the level L of that entry (5..1).
- R7: On success `done_fault`=0, `done_cause`=0, and `done_paddr` = {last entry bits 51:12, virtual bits 11:0}. Entry bits 63:52 and 11:1 have no effect, and non-leaf entries give the next table frame from bits 51:12.
- R8: While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays asserted with an unchanged address. No new read is issued until the pending response arrives.
- R9: `req_ready` is 1 only when idle. A request held during a walk is not taken, and that walk's read count is unchanged.
- R10: The depth of a walk is the mode at acceptance. A mode write during a walk does not change that walk's read count.
- R11: `done_valid` is a one-cycle pulse. `req_ready` returns to 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 64 | Control word write value; bit 12 is the depth mode |
| long_mode_i | input | 1 | High while the processor runs in 64-bit mode |
| deep_mode_o | output | 1 | Current depth mode (1 = five levels) |
| cfg_err_o | output | 1 | One-cycle pulse on a refused mode change |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root_frame | input | 40 | Frame number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| done_valid | output | 1 | Result valid (one cycle) |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 non-canonical, 2 not present |
| done_level | output | 3 | Level of a not-present fault, else 0 |
| done_paddr | output | 52 | Translated physical address |

## Verification
A wrong level counter or a slipped index slice shows first on `mem_req_addr` at the very next read handshake, and the bench compares each read address with its own walk over the same memory image. A depth captured at the wrong time shows as one read too many or too few before `done_valid`. A stale mode register shows on `deep_mode_o` or `cfg_err_o` within one cycle of the write, and the bench checks both against its model every clock. A canonical check tied to the wrong mode shows as a fault, or a memory read, in the cycle after acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_BITS   = 64;
    localparam int PA_BITS   = 52;
    localparam int IDX_BITS  = 9;
    localparam int OFF_BITS  = 12;
    localparam int ENT_BITS  = 64;
    localparam int LEVELS    = 5;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_NONCANON   = 2'd1,
        CAUSE_NOTPRESENT = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
    parameter int VA_W    = 64,
    parameter int MSB_LO  = 47,
    parameter int MSB_HI  = 56
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            five,
    output logic            ok
);
    logic [VA_W-1-MSB_LO:0] upper_lo;
    logic [VA_W-1-MSB_HI:0] upper_hi;
    logic                   ok_lo;
    logic                   ok_hi;

    always_comb begin
        upper_lo = vaddr[VA_W-1:MSB_LO];
        upper_hi = vaddr[VA_W-1:MSB_HI];
        ok_lo    = (&upper_lo) | ~(|upper_lo);
        ok_hi    = (&upper_hi) | ~(|upper_hi);
        ok       = five ? ok_hi : ok_lo;
    end
endmodule

// File: rtl/ptw_mode_reg.sv
module ptw_mode_reg #(
    parameter int DATA_W   = 64,
    parameter int MODE_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              long_mode,
    output logic              mode_q,
    output logic              err_q
);
    logic wr_bit;
    logic refuse;

    always_comb begin
        wr_bit = wr_data[MODE_BIT];
        refuse = wr_en && long_mode && (wr_bit != mode_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= refuse;
            if (wr_en && !refuse) begin
                mode_q <= wr_bit;
            end
        end
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 52,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12,
    parameter int ENT_W   = 64,
    parameter int LVL_MAX = 5,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int ENT_SH  = OFF_W - IDX_W,
    localparam int LVL_W   = $clog2(LVL_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root_frame,
    input  logic               canon_ok,
    input  logic               mode,
    output logic               walk_five,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               done_valid,
    output logic               done_fault,
    output logic [1:0]         done_cause,
    output logic [LVL_W-1:0]   done_level,
    output logic [PA_W-1:0]    done_paddr
);
    localparam logic [LVL_W-1:0] TOP_FIVE = LVL_W'(LVL_MAX);
    localparam logic [LVL_W-1:0] TOP_FOUR = LVL_W'(LVL_MAX - 1);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

    walk_state_e        state_q, state_d;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] base_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               five_q;
    logic [IDX_W-1:0]   idx;
    logic               present;
    logic               last_lvl;
    logic [FRAME_W-1:0] ent_frame;
    logic               accept;
    int                 shamt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shamt     = OFF_W + IDX_W * ((lvl_q == '0) ? 0 : (int'(lvl_q) - 1));
        idx       = IDX_W'(va_q >> shamt);
        present   = mem_rsp_data[0];
        last_lvl  = (lvl_q == LVL_ONE);
        ent_frame = mem_rsp_data[PA_W-1:OFF_W];
        accept    = (state_q == ST_IDLE) && req_valid;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = canon_ok ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = (!present || last_lvl) ? ST_DONE : ST_ISSUE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        done_valid    = (state_q == ST_DONE);
        mem_req_addr  = {base_q, idx, {ENT_SH{1'b0}}};
        walk_five     = five_q;
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            base_q     <= '0;
            lvl_q      <= '0;
            five_q     <= 1'b0;
            done_fault <= 1'b0;
            done_cause <= CAUSE_NONE;
            done_level <= '0;
            done_paddr <= '0;
        end else if (accept) begin
            va_q       <= req_vaddr;
            base_q     <= req_root_frame;
            five_q     <= mode;
            lvl_q      <= mode ? TOP_FIVE : TOP_FOUR;
            done_paddr <= '0;
            done_level <= '0;
            done_fault <= !canon_ok;
            done_cause <= canon_ok ? CAUSE_NONE : CAUSE_NONCANON;
        end else if (state_q == ST_WAIT && mem_rsp_valid) begin
            if (!present) begin
                done_fault <= 1'b1;
                done_cause <= CAUSE_NOTPRESENT;
                done_level <= lvl_q;
            end else if (last_lvl) begin
                done_fault <= 1'b0;
                done_cause <= CAUSE_NONE;
                done_paddr <= {ent_frame, va_q[OFF_W-1:0]};
            end else begin
                base_q <= ent_frame;
                lvl_q  <= lvl_q - LVL_ONE;
            end
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W     = VA_BITS,
    parameter int PA_W     = PA_BITS,
    parameter int IDX_W    = IDX_BITS,
    parameter int OFF_W    = OFF_BITS,
    parameter int ENT_W    = ENT_BITS,
    parameter int LVL_MAX  = LEVELS,
    parameter int MODE_BIT = 12,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = $clog2(LVL_MAX + 1),
    localparam int MSB_LO  = OFF_W + IDX_W * (LVL_MAX - 1) - 1,
    localparam int MSB_HI  = OFF_W + IDX_W * LVL_MAX - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [63:0]        cfg_wr_data,
    input  logic               long_mode_i,
    output logic               deep_mode_o,
    output logic               cfg_err_o,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root_frame,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               done_valid,
    output logic               done_fault,
    output logic [1:0]         done_cause,
    output logic [LVL_W-1:0]   done_level,
    output logic [PA_W-1:0]    done_paddr
);
    logic canon_ok;
    logic walk_five;

    ptw_mode_reg #(.DATA_W(64), .MODE_BIT(MODE_BIT)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .long_mode (long_mode_i),
        .mode_q    (deep_mode_o),
        .err_q     (cfg_err_o)
    );

    ptw_canon #(.VA_W(VA_W), .MSB_LO(MSB_LO), .MSB_HI(MSB_HI)) u_canon (
        .vaddr (req_vaddr),
        .five  (deep_mode_o),
        .ok    (canon_ok)
    );

    ptw_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .ENT_W(ENT_W), .LVL_MAX(LVL_MAX)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_root_frame (req_root_frame),
        .canon_ok       (canon_ok),
        .mode           (deep_mode_o),
        .walk_five      (walk_five),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .done_valid     (done_valid),
        .done_fault     (done_fault),
        .done_cause     (done_cause),
        .done_level     (done_level),
        .done_paddr     (done_paddr)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int PA_W     = 52,
    parameter int LVL_W    = 3,
    parameter int LVL_MAX  = 5,
    parameter int MODE_BIT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [63:0]      cfg_wr_data,
    input logic             long_mode_i,
    input logic             deep_mode_o,
    input logic             cfg_err_o,
    input logic             req_valid,
    input logic             req_ready,
    input logic             canon_ok,
    input logic             walk_five,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             done_valid,
    input logic [1:0]       done_cause,
    input logic [LVL_W-1:0] done_level
);
    p_refused_write_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && long_mode_i && (cfg_wr_data[MODE_BIT] != deep_mode_o)) |=> (cfg_err_o && $stable(deep_mode_o)));

    p_err_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !cfg_err_o || $past(cfg_wr_en && long_mode_i));

    p_noncanon_faults_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !canon_ok) |=> (done_valid && done_cause == 2'd1 && !mem_req_valid));

    p_notpresent_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_cause == 2'd2) |-> (done_level != '0 && done_level <= LVL_W'(LVL_MAX)));

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done_valid) |-> !req_ready);

    p_depth_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !done_valid) |=> $stable(walk_five));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));
endmodule

bind ptw_top ptw_checker #(
    .PA_W(PA_W), .LVL_W(LVL_W), .LVL_MAX(LVL_MAX), .MODE_BIT(MODE_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_data   (cfg_wr_data),
    .long_mode_i   (long_mode_i),
    .deep_mode_o   (deep_mode_o),
    .cfg_err_o     (cfg_err_o),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .canon_ok      (canon_ok),
    .walk_five     (walk_five),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_cause    (done_cause),
    .done_level    (done_level)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic        long_mode_i = 1'b0;
    logic        deep_mode_o, cfg_err_o;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [39:0] req_root_frame = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid, done_fault;
    logic [1:0]  done_cause;
    logic [2:0]  done_level;
    logic [51:0] done_paddr;

    always #10 clk = ~clk;

    ptw_top dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] pmem [logic [51:0]];
    logic [51:0] exp_addrs[$];
    int          reads;
    bit          stall_en = 0;
    bit          rsp_pending = 0;
    logic [51:0] rsp_addr;

    task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [51:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 64'd0;
    endfunction

    // Memory responder: decide ready, answer, and record reads
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd_mem(rsp_addr);
                rsp_pending   = 0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_DEAD_BEEF;
            end
            mem_req_ready = stall_en ? ~mem_req_ready : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                rsp_pending = 1;
                rsp_addr    = mem_req_addr;
                reads++;
                if (exp_addrs.size() > 0) begin
                    logic [51:0] e;
                    e = exp_addrs.pop_front();
                    chk(mem_req_addr == e, "R3/R4 entry address", mem_req_addr, e);
                end else begin
                    chk(0, "R5/R8 unexpected read", mem_req_addr, 0);
                end
            end
        end
    end

    // Mode register model, compared every clock
    bit exp_mode = 0, exp_err = 0, nxt_mode = 0, nxt_err = 0;
    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                nxt_mode = 0; nxt_err = 0;
            end else begin
                nxt_err = cfg_wr_en && long_mode_i && (cfg_wr_data[12] != exp_mode);
                nxt_mode = (cfg_wr_en && !nxt_err) ? cfg_wr_data[12] : exp_mode;
            end
            @(negedge clk);
            exp_mode = nxt_mode;
            exp_err  = nxt_err;
            if (rst_n) begin
                chk(deep_mode_o == exp_mode, "R1 deep_mode_o", deep_mode_o, exp_mode);
                chk(cfg_err_o == exp_err, "R2 cfg_err_o", cfg_err_o, exp_err);
            end
        end
    end

    // Reference walk
    task automatic ref_walk(input logic [63:0] va, input logic [39:0] root, input bit five,
                            output bit fault, output int cause, output int lvl,
                            output logic [51:0] pa, output int nreads);
        logic [39:0] b;
        logic [63:0] ent;
        logic [51:0] a;
        bit canon;
        int top;
        exp_addrs.delete();
        fault = 0; cause = 0; lvl = 0; pa = '0; nreads = 0;
        if (five) canon = (va[63:56] == 8'h00) || (va[63:56] == 8'hFF);
        else      canon = (va[63:47] == 17'h0) || (va[63:47] == 17'h1FFFF);
        if (!canon) begin
            fault = 1; cause = 1; return;
        end
        top = five ? 5 : 4;
        b = root;
        for (int l = top; l >= 1; l--) begin
            a = {b, va[12 + 9*(l-1) +: 9], 3'b000};
            exp_addrs.push_back(a);
            nreads++;
            ent = rd_mem(a);
            if (!ent[0]) begin
                fault = 1; cause = 2; lvl = l; return;
            end
            if (l == 1) pa = {ent[51:12], va[11:0]};
            else        b = ent[51:12];
        end
    endtask

    // Build a chain of tables; np_lvl != 0 writes a not-present entry there
    task automatic map_page(input logic [63:0] va, input logic [39:0] root, input bit five,
                            input logic [39:0] frame, input logic [39:0] salt, input int np_lvl);
        logic [39:0] b, nb;
        logic [51:0] a;
        int top;
        top = five ? 5 : 4;
        b = root;
        for (int l = top; l >= 1; l--) begin
            a = {b, va[12 + 9*(l-1) +: 9], 3'b000};
            if (l == np_lvl) begin
                pmem[a] = {12'hFFF, 40'hABCDE_12345, 12'hFFE};
                return;
            end
            if (l == 1) pmem[a] = {12'hA5C, frame, 12'h0E3};
            else begin
                nb = salt + 40'(l);
                pmem[a] = {12'h7B1, nb, 12'h6F1};
                b = nb;
            end
        end
    endtask

    task automatic cfg_write(input bit v, input bit lm);
        @(negedge clk);
        long_mode_i = lm;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = {51'h5_5555_5555_5555, v, 12'hAAA};
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
        long_mode_i = 1'b0;
    endtask

    // Run one walk. hold keeps req_valid high while busy; mid_wr flips the mode mid-walk.
    task automatic run_walk(input string name, input logic [63:0] va, input logic [39:0] root,
                            input bit hold, input bit mid_wr);
        bit e_fault; int e_cause, e_lvl, e_n; logic [51:0] e_pa;
        int cyc;
        bit five;
        @(negedge clk);
        five = deep_mode_o;
        ref_walk(va, root, five, e_fault, e_cause, e_lvl, e_pa, e_n);
        reads = 0;
        chk(req_ready == 1'b1, {"R9 ready before ", name}, req_ready, 1);
        req_valid = 1'b1; req_vaddr = va; req_root_frame = root;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!hold) req_valid = 1'b0;
            if (mid_wr && cyc == 2) begin
                cfg_wr_en = 1'b1; cfg_wr_data = {51'h0, ~five, 12'h0};
            end else if (mid_wr && cyc == 3) begin
                cfg_wr_en = 1'b0; cfg_wr_data = '0;
            end
            if (done_valid) break;
            chk(req_ready == 1'b0, {"R9 busy ", name}, req_ready, 0);
            if (cyc > 200) begin
                chk(0, {"R11 no completion ", name}, cyc, 0);
                break;
            end
        end
        req_valid = 1'b0;
        chk(done_fault == e_fault, {"R5/R6/R7 fault ", name}, done_fault, e_fault);
        chk(done_cause == 2'(e_cause), {"R5/R6/R7 cause ", name}, done_cause, e_cause);
        chk(done_level == 3'(e_lvl), {"R6 level ", name}, done_level, e_lvl);
        if (!e_fault) chk(done_paddr == e_pa, {"R7 paddr ", name}, done_paddr, e_pa);
        chk(reads == e_n, {"R3/R4/R10 read count ", name}, reads, e_n);
        if (e_cause == 1) chk(cyc == 1, {"R5 fault latency ", name}, cyc, 1);
        @(negedge clk);
        chk(done_valid == 1'b0, {"R11 pulse ", name}, done_valid, 0);
        chk(req_ready == 1'b1, {"R11 ready after ", name}, req_ready, 1);
        if (mid_wr) cfg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] va4, va5, vnp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
        chk(done_valid == 1'b0, "R11 reset done", done_valid, 0);
        chk(mem_req_valid == 1'b0, "R8 reset mem_req_valid", mem_req_valid, 0);
        chk(deep_mode_o == 1'b0, "R1 reset mode", deep_mode_o, 0);

        // R3 / R7: four-level translation
        va4 = 64'h0000_5A3C_9E71_2468;
        map_page(va4, 40'h00010, 0, 40'h12345_6789A, 40'h00100, 0);
        run_walk("four-level", va4, 40'h00010, 0, 0);
        // R3: upper-half canonical address
        va4 = 64'hFFFF_8123_4567_89AB;
        map_page(va4, 40'h00020, 0, 40'h0000F_EDCBA, 40'h00200, 0);
        run_walk("four-level high half", va4, 40'h00020, 0, 0);
        // R5: non-canonical in four-level mode (bit 47 set, upper zero)
        run_walk("noncanon four", 64'h0000_8000_0000_1000, 40'h00020, 0, 0);
        // R6: not present at level 2
        vnp = 64'h0000_1111_2222_3000;
        map_page(vnp, 40'h00030, 0, 40'h0, 40'h00300, 2);
        run_walk("notpresent L2", vnp, 40'h00030, 0, 0);
        // R6: empty root, not present at top level
        run_walk("notpresent L4", 64'h0000_0000_0000_0000, 40'h00777, 0, 0);

        // R2: refused change while in 64-bit mode, and same-value write
        cfg_write(1, 1);
        @(negedge clk);
        chk(deep_mode_o == 1'b0, "R2 refused change kept", deep_mode_o, 0);
        cfg_write(0, 1);
        // R1: accepted change outside 64-bit mode
        cfg_write(1, 0);
        @(negedge clk);
        chk(deep_mode_o == 1'b1, "R1 mode set", deep_mode_o, 1);

        // R4: five-level translation, with stalls on the request port (R8)
        va5 = 64'h00AB_CDEF_0123_4567;
        map_page(va5, 40'h00040, 1, 40'hFEDCB_A9876, 40'h00400, 0);
        stall_en = 1;
        run_walk("five-level stalled", va5, 40'h00040, 0, 0);
        stall_en = 0;
        // R5: bit 47 set is canonical in five-level mode
        va5 = 64'h0000_8000_0000_1ABC;
        map_page(va5, 40'h00050, 1, 40'h00042_00042, 40'h00500, 0);
        run_walk("five-level bit47", va5, 40'h00050, 0, 0);
        // R5: non-canonical in five-level mode (bit 60)
        run_walk("noncanon five", 64'h1000_0000_0000_0000, 40'h00050, 0, 0);
        // R6: not present at level 5
        run_walk("notpresent L5", 64'hFF80_0000_0000_0000, 40'h00888, 0, 0);
        // R9: request held during walk is not taken again
        run_walk("held request", 64'h00AB_CDEF_0123_4567, 40'h00040, 1, 0);
        // R10: mode cleared mid-walk, walk keeps five levels
        run_walk("mid-walk mode write", 64'h0000_8000_0000_1ABC, 40'h00050, 0, 1);
        @(negedge clk);
        chk(deep_mode_o == 1'b0, "R10 mode after walk", deep_mode_o, 0);
        // R10: back in four-level, same address is now non-canonical
        run_walk("after mode clear", 64'h0000_8000_0000_1ABC, 40'h00050, 0, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule